// File: doc/BRIEF.md
# Three-Wire Serial Memory Read Slave

This block is the device side of a three-wire serial memory link. It has a chip select, a serial clock, a serial data input and a serial data output that can be tri-stated. While chip select is high, the block samples the data input on each rising serial clock edge. It waits out any number of low "dummy" bits until it sees a start bit. It then takes a two-bit opcode and an address, most significant bit first. For a READ it streams 16-bit words out of an internal array.

The first output bit is a zero, driven on the edge that latches the last address bit. Each word follows most significant bit first. Reading continues into the next word, and wraps from the top address to address zero, for as long as chip select stays high. Any other opcode leaves the output released until chip select drops.

The serial pins are oversampled on a system clock. The array is filled through a synchronous parallel preload port on that same clock. The tri-state output is modelled as a data bit plus an output-enable flag.

Top module: `mw_read_slave`

## Requirements
- R1: While cs is low, do_oe is 0 one system clock later, and the decoder returns to idle. do_oe is also 0 out of reset.
- R2: In idle, a rising sk edge that samples di = 0 is discarded, for any number of such edges.
- R3: The start bit (di = 1) is followed by two opcode bits, and READ is 1 then 0. Any other pair (00, 01, 11) keeps do_oe at 0 for every later edge until cs falls.
- R4: The address is taken MSB first, ADDR_W bits. do_oe stays 0 up to and including the edge that latches the next-to-last address bit. On the edge that latches the last address bit, do_oe becomes 1 and do_val is 0.
- R5: Each following rising sk edge puts the next bit of the addressed word on do_val, bit 15 first and bit 0 last. do_val changes only in response to a rising sk edge.
- R6: The edge after bit 0 of a word delivers bit 15 of the word at the next address, with no extra zero bit in between.
- R7: Reading past the all-ones address continues at address 0.
- R8: With ADDR_W = 7, exactly one don't-care bit sits between the opcode and the seven address bits, and its value has no effect on the word read.
- R9: A pulse of pre_we writes pre_data to location pre_addr at the next system clock edge, and a later read returns it.
- R10: sk edges and di values applied while cs is low start no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples sk, clocks the preload port) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_val | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_val (0 = high impedance) |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload address |
| pre_data | input | WORD_W | Preload data |

## Verification
The bench builds two copies of the block. One uses the default ADDR_W = 6, which brings the 64-word wrap from address 63 to 0 within a short read. The other uses ADDR_W = 7, which exercises the extra don't-care slot and a 128-word array. Both copies use WORD_W = 16. Each copy is preloaded with a distinct address-dependent pattern, so a wrong address, bit order or word boundary shows up as a data mismatch.

// File: rtl/mw_read_slave.sv
module mw_read_slave #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  output logic              do_val,
  output logic              do_oe,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD   = (ADDR_W == 7) ? 1 : 0;
  localparam int NA    = ADDR_W + PAD;
  localparam int CW    = $clog2(WORD_W + NA + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_IGN} st_t;

  st_t               st;
  logic              sk_q, opc_hi;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [WORD_W-1:0] word_sh;
  logic [WORD_W-1:0] mem [DEPTH];

  wire              sk_rise   = cs & sk & ~sk_q;
  wire [ADDR_W-1:0] addr_next = {addr_sh[ADDR_W-2:0], di};
  wire [ADDR_W-1:0] addr_inc  = addr_sh + 1'b1;

  always_ff @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      opc_hi  <= 1'b0;
      addr_sh <= '0;
      word_sh <= '0;
      do_val  <= 1'b0;
      do_oe   <= 1'b0;
    end else if (!cs) begin
      st    <= S_IDLE;
      cnt   <= '0;
      do_oe <= 1'b0;
    end else if (sk_rise) begin
      case (st)
        S_IDLE: if (di) begin
          st  <= S_OPC;
          cnt <= '0;
        end
        S_OPC: begin
          if (cnt == '0) begin
            opc_hi <= di;
            cnt    <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            st  <= (opc_hi && !di) ? S_ADDR : S_IGN;
          end
        end
        S_ADDR: begin
          addr_sh <= addr_next;
          if (cnt == CW'(NA - 1)) begin
            cnt     <= '0;
            word_sh <= mem[addr_next];
            do_val  <= 1'b0;
            do_oe   <= 1'b1;
            st      <= S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          do_val <= word_sh[WORD_W-1];
          if (cnt == CW'(WORD_W - 1)) begin
            cnt     <= '0;
            addr_sh <= addr_inc;
            word_sh <= mem[addr_inc];
          end else begin
            cnt     <= cnt + 1'b1;
            word_sh <= word_sh << 1;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  cs_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_oe);
  // R2
  dummy_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && sk_rise && !di) |=> (st == S_IDLE));
  // R3
  bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !do_oe);
  // R4
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> !do_val);
  // R5
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sk_rise |=> $stable(do_val));
endmodule

// File: tb/mw_read_slave_bench.sv
module mw_read_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do6, oe6, do7, oe7;
  logic we6 = 1'b0, we7 = 1'b0;
  logic [6:0]  paddr = '0;
  logic [15:0] pdata = '0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  mw_read_slave #(.ADDR_W(6), .WORD_W(16)) u_mw_read_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_val(do6), .do_oe(oe6), .pre_we(we6), .pre_addr(paddr[5:0]), .pre_data(pdata));

  mw_read_slave #(.ADDR_W(7), .WORD_W(16)) u_mw_read_slave_w7 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_val(do7), .do_oe(oe7), .pre_we(we7), .pre_addr(paddr), .pre_data(pdata));

  function automatic logic [15:0] pat(int a, int salt);
    return 16'((a * 1699) ^ (a << 11) ^ salt);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(bit b);
    @(negedge clk) di = b;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_set(bit v);
    @(negedge clk) cs = v;
    repeat (2) @(negedge clk);
  endtask

  function automatic bit out_v(bit w7); return w7 ? do7 : do6; endfunction
  function automatic bit out_e(bit w7); return w7 ? oe7 : oe6; endfunction

  task automatic get_word(bit w7, output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0);
      w[i] = out_v(w7);
    end
  endtask

  // Sends start, READ, optional don't-care, address; checks R4 along the way
  task automatic start_read(bit w7, int a, bit dc);
    int aw = w7 ? 7 : 6;
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    if (w7) pulse(dc);
    for (int i = aw - 1; i >= 1; i--) pulse(a[i]);
    chk(out_e(w7) == 1'b0, "R4 hiz before last addr bit", out_e(w7), 0);
    pulse(a[0]);
    chk(out_e(w7) == 1'b1 && out_v(w7) == 1'b0, "R4 leading zero",
        {out_e(w7), out_v(w7)}, 2);
  endtask

  task automatic t_preload();
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      paddr = 7'(a); pdata = pat(a, 16'h5A3C);
      we7 = 1'b1; we6 = (a < 64);
      if (a < 64) pdata = pat(a, 16'h5A3C);
      @(negedge clk);
      we6 = 1'b0; we7 = 1'b0;
      if (a < 64) begin
        @(negedge clk);
        paddr = 7'(a); pdata = pat(a, 16'h0C71); we6 = 1'b1;
        @(negedge clk);
        we6 = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    chk(oe6 == 1'b0 && oe7 == 1'b0, "R1 reset hiz", {oe6, oe7}, 0);
  endtask

  task automatic t_dummy_read();
    logic [15:0] w;
    cs_set(1'b1);
    for (int i = 0; i < 5; i++) pulse(1'b0);
    chk(oe6 == 1'b0, "R2 dummy clocks keep hiz", oe6, 0);
    start_read(1'b0, 21, 1'b0);
    get_word(1'b0, w);
    chk(w == pat(21, 16'h0C71), "R5 word at 21 (R2 dummies, R9 preload)", w, pat(21, 16'h0C71));
    get_word(1'b0, w);
    chk(w == pat(22, 16'h0C71), "R6 next word 22", w, pat(22, 16'h0C71));
    cs_set(1'b0);
    chk(oe6 == 1'b0, "R1 cs low releases", oe6, 0);
  endtask

  task automatic t_wrap();
    logic [15:0] w;
    cs_set(1'b1);
    start_read(1'b0, 62, 1'b0);
    for (int k = 0; k < 3; k++) begin
      get_word(1'b0, w);
      chk(w == pat((62 + k) % 64, 16'h0C71), "R7 wrap sequence", w, pat((62 + k) % 64, 16'h0C71));
    end
    cs_set(1'b0);
  endtask

  task automatic t_bad_opc(bit b1, bit b0);
    cs_set(1'b1);
    pulse(1'b1); pulse(b1); pulse(b0);
    for (int i = 0; i < 24; i++) pulse(i[0]);
    chk(oe6 == 1'b0, "R3 unsupported opcode stays hiz", oe6, 0);
    cs_set(1'b0);
  endtask

  task automatic t_abort();
    logic [15:0] w;
    cs_set(1'b1);
    start_read(1'b0, 5, 1'b0);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    cs_set(1'b0);
    chk(oe6 == 1'b0, "R1 abort mid-word releases", oe6, 0);
    cs_set(1'b1);
    start_read(1'b0, 40, 1'b0);
    get_word(1'b0, w);
    chk(w == pat(40, 16'h0C71), "R1 fresh read after abort", w, pat(40, 16'h0C71));
    cs_set(1'b0);
  endtask

  task automatic t_cs_low_ignored();
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    for (int i = 0; i < 6; i++) pulse(1'b0);
    chk(oe6 == 1'b0, "R10 cs low edges keep hiz", oe6, 0);
    cs_set(1'b1);
    pulse(1'b0); pulse(1'b0);
    chk(oe6 == 1'b0, "R10 no command carried over", oe6, 0);
    cs_set(1'b0);
  endtask

  task automatic t_w7();
    logic [15:0] w;
    cs_set(1'b1);
    start_read(1'b1, 100, 1'b1);
    get_word(1'b1, w);
    chk(w == pat(100, 16'h5A3C), "R8 w7 word 100 dc=1", w, pat(100, 16'h5A3C));
    cs_set(1'b0);
    cs_set(1'b1);
    start_read(1'b1, 127, 1'b0);
    get_word(1'b1, w);
    chk(w == pat(127, 16'h5A3C), "R8 w7 word 127 dc=0", w, pat(127, 16'h5A3C));
    get_word(1'b1, w);
    chk(w == pat(0, 16'h5A3C), "R7 w7 wrap to 0", w, pat(0, 16'h5A3C));
    cs_set(1'b0);
  endtask

  initial begin : wdog
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_preload();
    t_dummy_read();
    t_wrap();
    t_bad_opc(1'b1, 1'b1);
    t_bad_opc(1'b0, 1'b1);
    t_bad_opc(1'b0, 1'b0);
    t_abort();
    t_cs_low_ignored();
    t_w7();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule